// File: doc/BRIEF.md
# Multi-mode 16-bit timer

This block is a 16-bit up-counting timer that a processor programs through a byte-wide register port. One counter core serves eight operating modes: single-shot and free-running timeouts, counting of pin transitions, single-output PWM, input capture, output compare, gated counting and a combined capture/compare mode. It samples one timer input pin, drives one timer output pin and raises a single interrupt pulse. A filter chooses which class of event may reach that interrupt.

The system clock reaches the counter through a power-of-two prescaler. Software loads the count, the reload value and the match value one byte at a time, then writes the control byte to start the timer. Reading the count's high byte freezes a copy of its low byte, so a running 16-bit count can be read as two bytes that belong together.

Top module: `multimode_timer`

## Requirements
- R1: In modes 000 (one-shot), 001 (continuous), 010 (pin count), 011 (PWM), 100 (capture), 110 (gated) and 111 (capture/compare), each count step adds one. A step taken while the count equals the reload value instead loads 0001h, toggles timerOut and counts as a reload event.
- R2: Control bits 5:3 hold a prescale code c, which divides by 2^c. Once the timer is enabled, ticks fall on the 2^c-th clock after enabling and then every 2^c clocks. The prescaler restarts whenever the timer is disabled.
- R3: A write to the control byte (address 6) copies its polarity bit 6 onto timerOut, and its bit 7 enables the timer. In mode 000 the first reload clears bit 7, so the timer stops and its output stays where the toggle left it.
- R4: Mode 010 ignores the prescaler and takes one step per transition of timerIn, seen after a two-flop synchronizer. The transition is rising when polarity is 0 and falling when polarity is 1.
- R5: Mode 011 toggles timerOut when it takes a step with the count equal to the match value (addresses 4 and 5), and toggles it again at the reload.
- R6: In mode 100, a selected timerIn edge copies the current count into the match pair and counts as an input event, and counting carries on.
- R7: Mode 111 takes no steps until the first selected edge after enabling. Each later selected edge captures the count in the same way as R6.
- R8: irq is a one-clock pulse in the cycle after an event. The select field (address 7, bits 1:0) passes only input events when set to 10 and only reload or compare events when set to 11; 00 and 01 pass both.
- R9: Reading address 0 returns the count's high byte and latches its low byte, and reading address 1 returns the latched byte. Read data appears on busRdata in the cycle after busRd.
- R10: Mode 110 steps on ticks only while the synchronized timerIn is at its active level: high when polarity is 0, low when polarity is 1. The change to the inactive level is an input event.
- R11: Mode 101 steps on every tick with a 16-bit wraparound and never reloads. A step taken with the count equal to the reload value toggles timerOut and counts as a compare event.
- R12: Reset leaves the count at 0000h, reload at FFFFh, match at 0000h, control and select at 00h and timerOut at 0. The address map is: 0/1 count high/low, 2/3 reload high/low, 4/5 match high/low, 6 control, 7 select. A bus write to a register wins over any counter update of that register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe |
| busAddr | input | 3 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, registered |
| timerIn | input | 1 | Timer input pin, asynchronous |
| timerOut | output | 1 | Timer output pin |
| irq | output | 1 | Interrupt request pulse |

## Verification
Several relations are checked on every cycle by the assertions. A wrap always leaves the count at 0001h, and a capture copies the count into the match pair. The output inverts on a toggle strobe, a prescaler tick for a non-zero code is never followed straight away by another, a one-shot reload drops the enable bit, and every interrupt pulse follows an event. Other behaviour shows only in the bench's scenarios, where a behavioural reference model is compared with the outputs on each clock. These include the exact spacing of ticks, the edge polarity in counting, gating and capture, the delay before capture/compare starts, and the filtering of interrupt classes. The coherence of a two-byte count read is also shown there.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CNT_HI   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CNT_LO   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_RLD_HI   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_RLD_LO   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_MATCH_HI = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_MATCH_LO = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_CTRL     = 3'd6;
  localparam logic [ADDR_W-1:0] ADDR_SEL      = 3'd7;

  // control byte fields
  localparam int EN_BIT   = 7;
  localparam int POL_BIT  = 6;
  localparam int PRE_LSB  = 3;
  localparam int MODE_LSB = 0;

  typedef enum logic [2:0] {
    MODE_ONESHOT = 3'd0,
    MODE_CONT    = 3'd1,
    MODE_COUNT   = 3'd2,
    MODE_PWM     = 3'd3,
    MODE_CAPT    = 3'd4,
    MODE_CMP     = 3'd5,
    MODE_GATE    = 3'd6,
    MODE_CAPCMP  = 3'd7
  } tmrMode_e;

  typedef enum logic [1:0] {
    SEL_ALL0  = 2'b00,
    SEL_ALL1  = 2'b01,
    SEL_INPUT = 2'b10,
    SEL_RELD  = 2'b11
  } irqSel_e;

  typedef struct packed {
    logic inc;
    logic wrap;
    logic capture;
    logic toggle;
    logic forceOut;
    logic forceVal;
  } tmrStrobe_t;
endpackage

// File: rtl/mtmr_ctrl.sv
module mtmr_ctrl
  import mtmr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CODE_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              timerIn,
  input  logic              eqReload,
  input  logic              eqMatch,
  output tmrStrobe_t        strobe,
  output logic [DATA_W-1:0] ctrlReg,
  output logic [1:0]        irqSel,
  output logic              irq
);
  localparam int PRE_W = (1 << CODE_W) - 1;

  logic              ctrlWr, selWr;
  logic              enabled, polarity;
  logic [CODE_W-1:0] preCode;
  tmrMode_e          mode;
  logic [PRE_W-1:0]  preCnt, preMask;
  logic              tick;
  logic [SYNC_STAGES:0] syncQ;
  logic              inLvl, inPrev, inRise, inFall, edgeSel, gateOn, gateOff;
  logic              started;
  logic              step, reloadEv, inputEv, oneShotDone;

  assign ctrlWr   = busWr && (busAddr == ADDR_CTRL);
  assign selWr    = busWr && (busAddr == ADDR_SEL);
  assign enabled  = ctrlReg[EN_BIT];
  assign polarity = ctrlReg[POL_BIT];
  assign preCode  = ctrlReg[PRE_LSB +: CODE_W];
  assign mode     = tmrMode_e'(ctrlReg[MODE_LSB +: 3]);

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (ctrlWr) begin
      ctrlReg <= busWdata;
    end else if (oneShotDone) begin
      ctrlReg[EN_BIT] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqSel <= SEL_ALL0;
    else if (selWr) irqSel <= busWdata[1:0];
  end

  // power-of-two prescaler, restarted while disabled
  assign preMask = PRE_W'((32'd1 << preCode) - 32'd1);
  assign tick    = enabled && ((preCnt & preMask) == preMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else if (!enabled) preCnt <= '0;
    else preCnt <= preCnt + PRE_W'(1);
  end

  // input synchronizer and edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else syncQ <= {syncQ[SYNC_STAGES-1:0], timerIn};
  end

  assign inLvl   = syncQ[SYNC_STAGES-1];
  assign inPrev  = syncQ[SYNC_STAGES];
  assign inRise  = inLvl && !inPrev;
  assign inFall  = !inLvl && inPrev;
  assign edgeSel = polarity ? inFall : inRise;
  assign gateOn  = polarity ? !inLvl : inLvl;
  assign gateOff = polarity ? inRise : inFall;

  // capture/compare start flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) started <= 1'b0;
    else if (!enabled) started <= 1'b0;
    else if (mode == MODE_CAPCMP && edgeSel) started <= 1'b1;
  end

  // step qualification per mode
  always_comb begin
    unique case (mode)
      MODE_COUNT:  step = enabled && edgeSel;
      MODE_GATE:   step = tick && gateOn;
      MODE_CAPCMP: step = tick && started;
      default:     step = tick;
    endcase
  end

  // strobe generation
  always_comb begin
    strobe      = '0;
    reloadEv    = 1'b0;
    inputEv     = 1'b0;
    oneShotDone = 1'b0;
    if (step) begin
      if (mode == MODE_CMP) begin
        strobe.inc = 1'b1;
        if (eqReload) begin
          strobe.toggle = 1'b1;
          reloadEv      = 1'b1;
        end
      end else if (eqReload) begin
        strobe.wrap   = 1'b1;
        strobe.toggle = 1'b1;
        reloadEv      = 1'b1;
        oneShotDone   = (mode == MODE_ONESHOT);
      end else begin
        strobe.inc = 1'b1;
        if (mode == MODE_PWM && eqMatch) strobe.toggle = 1'b1;
      end
    end
    strobe.capture = enabled && edgeSel &&
                     ((mode == MODE_CAPT) || (mode == MODE_CAPCMP && started));
    if (strobe.capture) inputEv = 1'b1;
    if (enabled && mode == MODE_GATE && gateOff) inputEv = 1'b1;
    strobe.forceOut = ctrlWr;
    strobe.forceVal = busWdata[POL_BIT];
  end

  // interrupt qualification
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irq <= 1'b0;
    else irq <= (reloadEv && irqSel != SEL_INPUT) || (inputEv && irqSel != SEL_RELD);
  end

  // R2: after a tick with a divider above one, the next clock holds no tick
  a_r2_prescale_gap: assert property (@(posedge clk) disable iff (!rstN)
    (tick && preCode != '0 && !ctrlWr) |=> !tick);

  // R3: one-shot reload stops the timer
  a_r3_oneshot_stop: assert property (@(posedge clk) disable iff (!rstN)
    (oneShotDone && !ctrlWr) |=> !ctrlReg[EN_BIT]);

  // R7: capture/compare counts nothing before its start edge
  a_r7_wait_start: assert property (@(posedge clk) disable iff (!rstN)
    (enabled && mode == MODE_CAPCMP && !started) |-> !(strobe.inc || strobe.wrap));

  // R8: every interrupt pulse follows an event
  a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(reloadEv || inputEv));
endmodule

// File: rtl/mtmr_dp.sv
module mtmr_dp
  import mtmr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  tmrStrobe_t        strobe,
  input  logic [DATA_W-1:0] ctrlReg,
  input  logic [1:0]        irqSel,
  output logic [DATA_W-1:0] busRdata,
  output logic              eqReload,
  output logic              eqMatch,
  output logic              timerOut
);
  localparam int CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0]  count, reloadVal, matchVal;
  logic [DATA_W-1:0] lowLatch;
  logic cntHiWr, cntLoWr, rldHiWr, rldLoWr, matchHiWr, matchLoWr, cntWr, matchWr;

  assign cntHiWr   = busWr && (busAddr == ADDR_CNT_HI);
  assign cntLoWr   = busWr && (busAddr == ADDR_CNT_LO);
  assign rldHiWr   = busWr && (busAddr == ADDR_RLD_HI);
  assign rldLoWr   = busWr && (busAddr == ADDR_RLD_LO);
  assign matchHiWr = busWr && (busAddr == ADDR_MATCH_HI);
  assign matchLoWr = busWr && (busAddr == ADDR_MATCH_LO);
  assign cntWr     = cntHiWr || cntLoWr;
  assign matchWr   = matchHiWr || matchLoWr;

  assign eqReload = (count == reloadVal);
  assign eqMatch  = (count == matchVal);

  // counter: bus write wins over the step
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) count <= '0;
    else if (cntHiWr) count[CNT_W-1:DATA_W] <= busWdata;
    else if (cntLoWr) count[DATA_W-1:0] <= busWdata;
    else if (strobe.wrap) count <= CNT_W'(1);
    else if (strobe.inc) count <= count + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reloadVal <= '1;
    else if (rldHiWr) reloadVal[CNT_W-1:DATA_W] <= busWdata;
    else if (rldLoWr) reloadVal[DATA_W-1:0] <= busWdata;
  end

  // match pair doubles as the capture register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) matchVal <= '0;
    else if (matchHiWr) matchVal[CNT_W-1:DATA_W] <= busWdata;
    else if (matchLoWr) matchVal[DATA_W-1:0] <= busWdata;
    else if (strobe.capture) matchVal <= count;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timerOut <= 1'b0;
    else if (strobe.forceOut) timerOut <= strobe.forceVal;
    else if (strobe.toggle) timerOut <= !timerOut;
  end

  // registered read port with coherent low-byte latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata <= '0;
      lowLatch <= '0;
    end else if (busRd) begin
      unique case (busAddr)
        ADDR_CNT_HI: begin
          busRdata <= count[CNT_W-1:DATA_W];
          lowLatch <= count[DATA_W-1:0];
        end
        ADDR_CNT_LO:   busRdata <= lowLatch;
        ADDR_RLD_HI:   busRdata <= reloadVal[CNT_W-1:DATA_W];
        ADDR_RLD_LO:   busRdata <= reloadVal[DATA_W-1:0];
        ADDR_MATCH_HI: busRdata <= matchVal[CNT_W-1:DATA_W];
        ADDR_MATCH_LO: busRdata <= matchVal[DATA_W-1:0];
        ADDR_CTRL:     busRdata <= ctrlReg;
        default:       busRdata <= {{(DATA_W-2){1'b0}}, irqSel};
      endcase
    end
  end

  // R1: a wrap leaves the count at one
  a_r1_wrap_one: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrap && !cntWr) |=> count == CNT_W'(1));

  // R5: a toggle strobe inverts the output
  a_r5_toggle: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.toggle && !strobe.forceOut) |=> timerOut != $past(timerOut));

  // R6: capture copies the count into the match pair
  a_r6_capture_copy: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !matchWr) |=> matchVal == $past(count));

  // R9: a high-byte read freezes the low byte
  a_r9_latch: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == ADDR_CNT_HI) |=> lowLatch == $past(count[DATA_W-1:0]));
endmodule

// File: rtl/multimode_timer.sv
module multimode_timer
  import mtmr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CODE_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [2:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              timerIn,
  output logic              timerOut,
  output logic              irq
);
  tmrStrobe_t        strobe;
  logic [DATA_W-1:0] ctrlReg;
  logic [1:0]        irqSel;
  logic              eqReload, eqMatch;

  mtmr_ctrl #(.DATA_W(DATA_W), .CODE_W(CODE_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .timerIn(timerIn), .eqReload(eqReload), .eqMatch(eqMatch),
    .strobe(strobe), .ctrlReg(ctrlReg), .irqSel(irqSel), .irq(irq)
  );

  mtmr_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .strobe(strobe), .ctrlReg(ctrlReg), .irqSel(irqSel),
    .busRdata(busRdata), .eqReload(eqReload), .eqMatch(eqMatch), .timerOut(timerOut)
  );
endmodule

// File: tb/multimode_timer_bench.sv
module multimode_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic       timerIn = 1'b0;
  logic [7:0] busRdata;
  logic       timerOut, irq;

  int    vecs = 0;
  int    errs = 0;
  int    irqSeen = 0;
  string curReq = "R12";

  // reference model state
  int mCount = 0, mReload = 16'hFFFF, mMatch = 0, mCtrl = 0, mSel = 0;
  int mLatch = 0, mPre = 0, mRdata = 0;
  bit mOut = 0, mIrq = 0, mStarted = 0;
  bit inHist[$] = '{0, 0, 0};

  always #(CLK_PERIOD/2) clk = ~clk;

  multimode_timer u_multimode_timer (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .timerIn(timerIn),
    .timerOut(timerOut), .irq(irq)
  );

  always @(posedge clk) begin : refModel
    int en, pol, code, mode, s2, s3, edg, tick, step, rEv, iEv;
    int nCount, nMatch, nCtrl, stopNow;
    bit nOut;
    if (!rstN) begin
      mCount = 0; mReload = 16'hFFFF; mMatch = 0; mCtrl = 0; mSel = 0;
      mLatch = 0; mPre = 0; mRdata = 0; mOut = 0; mIrq = 0; mStarted = 0;
      inHist = '{0, 0, 0};
    end else begin
      en = (mCtrl >> 7) & 1; pol = (mCtrl >> 6) & 1;
      code = (mCtrl >> 3) & 7; mode = mCtrl & 7;
      s2 = inHist[1]; s3 = inHist[2];
      edg = pol ? (!s2 && s3) : (s2 && !s3);
      tick = en && ((mPre % (1 << code)) == (1 << code) - 1);
      case (mode)
        2: step = en && edg;
        6: step = tick && (pol ? !s2 : s2);
        7: step = tick && mStarted;
        default: step = tick;
      endcase
      rEv = 0; iEv = 0; stopNow = 0;
      nCount = mCount; nMatch = mMatch; nCtrl = mCtrl; nOut = mOut;
      if (step) begin
        if (mode == 5) begin
          nCount = (mCount + 1) & 16'hFFFF;
          if (mCount == mReload) begin nOut = !mOut; rEv = 1; end
        end else if (mCount == mReload) begin
          nCount = 1; nOut = !mOut; rEv = 1; stopNow = (mode == 0);
        end else begin
          nCount = (mCount + 1) & 16'hFFFF;
          if (mode == 3 && mCount == mMatch) nOut = !mOut;
        end
      end
      if (en && edg && (mode == 4 || (mode == 7 && mStarted))) begin
        nMatch = mCount; iEv = 1;
      end
      if (en && mode == 6 && (pol ? (s2 && !s3) : (!s2 && s3))) iEv = 1;
      if (stopNow) nCtrl = mCtrl & 8'h7F;
      mIrq = (rEv && mSel != 2) || (iEv && mSel != 3);
      if (busRd) begin
        case (busAddr)
          3'd0: begin mRdata = (mCount >> 8) & 8'hFF; mLatch = mCount & 8'hFF; end
          3'd1: mRdata = mLatch;
          3'd2: mRdata = (mReload >> 8) & 8'hFF;
          3'd3: mRdata = mReload & 8'hFF;
          3'd4: mRdata = (mMatch >> 8) & 8'hFF;
          3'd5: mRdata = mMatch & 8'hFF;
          3'd6: mRdata = mCtrl;
          default: mRdata = mSel;
        endcase
      end
      if (busWr) begin
        case (busAddr)
          3'd0: nCount = (int'(busWdata) << 8) | (mCount & 8'hFF);
          3'd1: nCount = (mCount & 16'hFF00) | int'(busWdata);
          3'd2: mReload = (int'(busWdata) << 8) | (mReload & 8'hFF);
          3'd3: mReload = (mReload & 16'hFF00) | int'(busWdata);
          3'd4: nMatch = (int'(busWdata) << 8) | (mMatch & 8'hFF);
          3'd5: nMatch = (mMatch & 16'hFF00) | int'(busWdata);
          3'd6: begin nCtrl = busWdata; nOut = busWdata[6]; end
          default: mSel = busWdata & 3;
        endcase
      end
      if (!en) mStarted = 0;
      else if (mode == 7 && edg) mStarted = 1;
      mPre = en ? (mPre + 1) % 128 : 0;
      mCount = nCount; mMatch = nMatch; mCtrl = nCtrl; mOut = nOut;
      inHist.push_front(timerIn);
      void'(inHist.pop_back());
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      if (irq) irqSeen++;
      vecs++;
      if (timerOut !== mOut || irq !== mIrq || busRdata !== 8'(mRdata)) begin
        errs++;
        $display("FAIL %s cycle compare: out/irq/rdata actual %0b/%0b/%02h expected %0b/%0b/%02h",
                 curReq, timerOut, irq, busRdata, mOut, mIrq, mRdata);
      end
    end
  end

  task automatic check(string req, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk); #1;
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int val);
    @(negedge clk); #1;
    busRd = 1'b1; busAddr = a;
    @(negedge clk); #1;
    busRd = 1'b0;
    val = busRdata;
  endtask

  task automatic rdChk(input logic [2:0] a, input int exp, input string req);
    int v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic rdModel(input logic [2:0] a, input string req);
    int v;
    rd(a, v);
    check(req, v, mRdata);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int hi, int lo);
    @(negedge clk); #1 timerIn = 1'b1;
    repeat (hi) @(negedge clk);
    #1 timerIn = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic setCount(int c, int r);
    wr(3'd0, 8'(c >> 8)); wr(3'd1, 8'(c));
    wr(3'd2, 8'(r >> 8)); wr(3'd3, 8'(r));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired in %s", curReq);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin : main
    int v, a, b;
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    idle(2);

    // R12 reset values and map
    curReq = "R12";
    check("R12 timerOut", timerOut, 0);
    rdChk(3'd0, 8'h00, "R12 count hi");
    rdChk(3'd1, 8'h00, "R12 count lo");
    rdChk(3'd2, 8'hFF, "R12 reload hi");
    rdChk(3'd3, 8'hFF, "R12 reload lo");
    rdChk(3'd4, 8'h00, "R12 match hi");
    rdChk(3'd6, 8'h00, "R12 control");
    rdChk(3'd7, 8'h00, "R12 select");

    // R9 coherent read
    curReq = "R9";
    wr(3'd0, 8'h12); wr(3'd1, 8'h34);
    rdChk(3'd0, 8'h12, "R9 high byte");
    wr(3'd1, 8'h99);
    rdChk(3'd1, 8'h34, "R9 latched low byte");
    rdChk(3'd0, 8'h12, "R9 high again");
    rdChk(3'd1, 8'h99, "R9 new low byte");

    // R1 continuous reload
    curReq = "R1";
    setCount(1, 5);
    wr(3'd6, 8'h81);
    irqSeen = 0;
    idle(30);
    check("R1 reload interrupts seen", int'(irqSeen > 3), 1);
    rdModel(3'd0, "R1 count hi running");
    rdModel(3'd1, "R1 count lo running");
    wr(3'd6, 8'h01);

    // R2 prescaler
    curReq = "R2";
    setCount(1, 3);
    wr(3'd6, 8'h91);
    idle(40);
    rdModel(3'd0, "R2 count hi");
    rdModel(3'd1, "R2 count lo");
    wr(3'd6, 8'h39);
    idle(20);
    wr(3'd6, 8'h01);

    // R3 one-shot
    curReq = "R3";
    wr(3'd6, 8'h40);
    check("R3 output forced to polarity", timerOut, 1);
    setCount(1, 4);
    wr(3'd6, 8'hC0);
    idle(10);
    check("R3 output toggled once", timerOut, 0);
    rdChk(3'd6, 8'h40, "R3 enable cleared");

    // R4 pin counting, rising then falling
    curReq = "R4";
    setCount(1, 3);
    wr(3'd6, 8'h82);
    repeat (4) pulse(3, 3);
    idle(4);
    wr(3'd6, 8'h02);
    rdChk(3'd0, 8'h00, "R4 count hi");
    rdChk(3'd1, 8'h02, "R4 four rising edges wrap");
    wr(3'd6, 8'hC2);
    repeat (3) pulse(2, 4);
    idle(4);
    rdModel(3'd0, "R4 falling count hi");
    rdModel(3'd1, "R4 falling count lo");
    wr(3'd6, 8'h02);

    // R5 PWM
    curReq = "R5";
    setCount(1, 6);
    wr(3'd4, 8'h00); wr(3'd5, 8'h03);
    wr(3'd7, 8'h03);
    wr(3'd6, 8'h83);
    idle(40);
    wr(3'd6, 8'h03);

    // R6 capture
    curReq = "R6";
    setCount(1, 16'hFFFF);
    wr(3'd5, 8'h00);
    wr(3'd7, 8'h02);
    wr(3'd6, 8'h84);
    idle(10);
    irqSeen = 0;
    pulse(3, 10);
    check("R6 capture interrupt", irqSeen, 1);
    wr(3'd6, 8'h04);
    rd(3'd0, v); rd(3'd1, a); rd(3'd5, b);
    check("R6 match captured nonzero", int'(b != 0), 1);
    check("R6 counting continued", int'(a > b), 1);
    check("R6 model match", b, mMatch & 8'hFF);

    // R7 capture/compare
    curReq = "R7";
    setCount(1, 16'hFFFF);
    wr(3'd6, 8'h87);
    idle(10);
    rdChk(3'd0, 8'h00, "R7 idle before start hi");
    rdChk(3'd1, 8'h01, "R7 idle before start lo");
    pulse(3, 10);
    pulse(3, 6);
    rdModel(3'd5, "R7 captured low byte");
    wr(3'd6, 8'h07);

    // R10 gated
    curReq = "R10";
    setCount(1, 16'hFFFF);
    wr(3'd6, 8'h86);
    idle(6);
    rdChk(3'd1, 8'h01, "R10 no count while gate low");
    irqSeen = 0;
    pulse(8, 6);
    check("R10 deassert interrupt", irqSeen, 1);
    rdModel(3'd0, "R10 count hi");
    rdModel(3'd1, "R10 count lo");
    wr(3'd6, 8'h06);

    // R11 compare
    curReq = "R11";
    setCount(1, 5);
    wr(3'd7, 8'h00);
    wr(3'd6, 8'h85);
    idle(20);
    wr(3'd6, 8'h05);
    rdChk(3'd0, 8'h00, "R11 count hi");
    rd(3'd1, v);
    check("R11 count ran past compare value", int'(v > 5), 1);

    // R8 interrupt filtering
    curReq = "R8";
    setCount(1, 2);
    wr(3'd7, 8'h02);
    wr(3'd6, 8'h81);
    irqSeen = 0;
    idle(20);
    check("R8 reload events blocked by select 10", irqSeen, 0);
    wr(3'd7, 8'h00);
    irqSeen = 0;
    idle(20);
    check("R8 reload events pass with select 00", int'(irqSeen > 0), 1);
    wr(3'd6, 8'h01);
    setCount(1, 16'hFFFF);
    wr(3'd7, 8'h03);
    wr(3'd6, 8'h84);
    irqSeen = 0;
    pulse(3, 10);
    check("R8 capture blocked by select 11", irqSeen, 0);
    wr(3'd6, 8'h04);
    idle(4);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule